// File: doc/BRIEF.md
# Control-Steered 16-bit Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit. It takes two data words and six single-bit steering controls. Every function comes out of one fixed chain of stages. Each operand may first be cleared and then complemented. The two conditioned words are then either ANDed or added, and the core result may be complemented on the way out. Two status flags, one for an all-zero result and one for a negative result, go with the result word.

No function is decoded from an opcode. Constants, pass-through, negation, increment, decrement, subtraction, AND and OR all come from the same hardware, through the identities -v = ~v + 1 and ~v = -v - 1. A datapath controller drives the six controls straight from an instruction field. The result is valid in the same cycle the inputs are applied.

Top module: `alu6_unit`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by zero before any complement is applied. `clr_b` does the same for operand B.
- R2: When `flip_a` is 1, the operand A value left after the clear stage is bitwise complemented. `flip_b` does the same for operand B.
- R3: When `use_add` is 0, the core result is the bitwise AND of the two conditioned operands. When it is 1, the core result is their sum modulo 2^W, and the carry out of the top bit is discarded.
- R4: When `flip_out` is 1, the result is the bitwise complement of the core result. Otherwise the result equals the core result.
- R5: `is_zero` is 1 exactly when every bit of `res` is 0.
- R6: `is_neg` equals the most significant bit of `res`, so it is never 1 at the same time as `is_zero`.
- R7: With the controls written as the bit string {clr_a, flip_a, clr_b, flip_b, use_add, flip_out}, the settings give these results: 101010 gives 0, 111111 gives 1, 001100 gives a, 000010 gives a+b, 010011 gives a-b, 000000 gives a&b, 010101 gives a|b, and 001111 gives -a. Every result is taken modulo 2^W.
- R8: The block holds no state. `res` and the flags are a function of the present inputs only, so they follow any input change within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| clr_a | input | 1 | Clear operand A |
| flip_a | input | 1 | Complement operand A after the clear stage |
| clr_b | input | 1 | Clear operand B |
| flip_b | input | 1 | Complement operand B after the clear stage |
| use_add | input | 1 | 0 selects AND, 1 selects modular add |
| flip_out | input | 1 | Complement the core result |
| res | output | W | Result word |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Result sign bit |

## Verification
The bench builds the unit at the default W = 16. At that width every control setting can be swept against edge words: zero, all ones, the sign boundary 0x7FFF/0x8000, and additions that carry out of bit 15. These sweeps reach the discarded carry, the clear-before-complement order and both status flags across the sign boundary. Pseudo-random words under all 64 control settings then cover combinations that no hand-picked list reaches.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
  // Six steering bits gathered in one place.
  typedef struct packed {
    logic clr_a;
    logic flip_a;
    logic clr_b;
    logic flip_b;
    logic use_add;
    logic flip_out;
  } alu6_ctrl_t;

  // Number of operand conditioning lanes.
  localparam int NUM_OPS = 2;
endpackage

// File: rtl/alu6_cond.sv
// Operand conditioning: the clear stage comes first, then the optional complement.
module alu6_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         clr,
  input  logic         flip,
  output logic [W-1:0] dout
);
  function automatic logic [W-1:0] condition(input logic [W-1:0] v,
                                             input logic c, input logic f);
    logic [W-1:0] t;
    t = c ? '0 : v;
    return f ? ~t : t;
  endfunction

  assign dout = condition(din, clr, flip);
endmodule

// File: rtl/alu6_core.sv
// Core function: AND, or a modular sum that drops the carry.
module alu6_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         add_sel,
  output logic [W-1:0] core
);
  function automatic logic [W-1:0] mod_sum(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W:0] wide;
    wide = {1'b0, p} + {1'b0, q};
    return wide[W-1:0];
  endfunction

  assign core = add_sel ? mod_sum(opa, opb) : (opa & opb);
endmodule

// File: rtl/alu6_post.sv
// Output complement and status flags.
module alu6_post #(
  parameter int W = 16
) (
  input  logic [W-1:0] core,
  input  logic         flip,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  logic [W-1:0] word;
  assign word    = flip ? ~core : core;
  assign res     = word;
  assign is_zero = ~|word;
  assign is_neg  = word[W-1];
endmodule

// File: rtl/alu6_unit.sv
module alu6_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         clr_a,
  input  logic         flip_a,
  input  logic         clr_b,
  input  logic         flip_b,
  input  logic         use_add,
  input  logic         flip_out,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  import alu6_pkg::*;

  alu6_ctrl_t ctl;
  assign ctl = '{clr_a: clr_a, flip_a: flip_a, clr_b: clr_b,
                 flip_b: flip_b, use_add: use_add, flip_out: flip_out};

  logic [W-1:0] op_raw  [NUM_OPS];
  logic [W-1:0] op_cond [NUM_OPS];
  logic         op_clr  [NUM_OPS];
  logic         op_flip [NUM_OPS];

  assign op_raw[0]  = a_in;
  assign op_raw[1]  = b_in;
  assign op_clr[0]  = ctl.clr_a;
  assign op_clr[1]  = ctl.clr_b;
  assign op_flip[0] = ctl.flip_a;
  assign op_flip[1] = ctl.flip_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    alu6_cond #(.W(W)) u_cond (
      .din (op_raw[g]),
      .clr (op_clr[g]),
      .flip(op_flip[g]),
      .dout(op_cond[g])
    );
  end

  // Named internal events for the checker.
  logic [W-1:0] cond_a, cond_b, core_out;
  assign cond_a = op_cond[0];
  assign cond_b = op_cond[1];

  alu6_core #(.W(W)) u_core (
    .opa    (cond_a),
    .opb    (cond_b),
    .add_sel(ctl.use_add),
    .core   (core_out)
  );

  alu6_post #(.W(W)) u_post (
    .core   (core_out),
    .flip   (ctl.flip_out),
    .res    (res),
    .is_zero(is_zero),
    .is_neg (is_neg)
  );
endmodule

// File: rtl/alu6_unit_chk.sv
module alu6_unit_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_in,
  input logic         clr_a,
  input logic         flip_a,
  input logic         clr_b,
  input logic         flip_b,
  input logic         use_add,
  input logic         flip_out,
  input logic [W-1:0] cond_a,
  input logic [W-1:0] cond_b,
  input logic [W-1:0] core_out,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         is_neg
);
  always_comb begin
    // R1
    clr_a_chk: assert (!(clr_a && !flip_a) || cond_a == '0);
    // R1
    clr_b_chk: assert (!(clr_b && !flip_b) || cond_b == '0);
    // R2
    clr_then_flip_chk: assert (!(clr_a && flip_a) || cond_a == '1);
    // R2
    flip_raw_chk: assert (!(!clr_a && flip_a) || (cond_a ^ a_in) == '1);
    // R3
    add_zero_chk: assert (!(use_add && cond_b == '0) || core_out == cond_a);
    // R3
    and_ones_chk: assert (!(!use_add && cond_b == '1) || core_out == cond_a);
    // R4
    out_flip_chk: assert (!flip_out || (res ^ core_out) == '1);
    // R5
    zero_flag_chk: assert (is_zero == ($countones(res) == 0));
    // R6
    flag_excl_chk: assert (!(is_zero && is_neg));
  end
endmodule

bind alu6_unit alu6_unit_chk #(.W(W)) u_chk (
  .a_in    (a_in),
  .clr_a   (clr_a),
  .flip_a  (flip_a),
  .clr_b   (clr_b),
  .flip_b  (flip_b),
  .use_add (use_add),
  .flip_out(flip_out),
  .cond_a  (cond_a),
  .cond_b  (cond_b),
  .core_out(core_out),
  .res     (res),
  .is_zero (is_zero),
  .is_neg  (is_neg)
);

// File: tb/test_alu6_unit.sv
module test_alu6_unit;
  localparam int W = 16;
  localparam int MODV = 65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a_in, b_in, res;
  logic clr_a, flip_a, clr_b, flip_b, use_add, flip_out, is_zero, is_neg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  alu6_unit #(.W(W)) i_alu6_unit (
    .a_in(a_in), .b_in(b_in), .clr_a(clr_a), .flip_a(flip_a), .clr_b(clr_b),
    .flip_b(flip_b), .use_add(use_add), .flip_out(flip_out),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  // Behavioural model on integers; control string order is clr_a..flip_out.
  function automatic int model(int a, int b, logic [5:0] c);
    int x, y, r;
    x = c[5] ? 0 : a;
    if (c[4]) x = MODV - 1 - x;
    y = c[3] ? 0 : b;
    if (c[2]) y = MODV - 1 - y;
    r = c[1] ? (x + y) % MODV : (x & y);
    if (c[0]) r = MODV - 1 - r;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply at a rising edge, observe at the following falling edge.
  task automatic apply(int a, int b, logic [5:0] c);
    @(posedge clk);
    a_in = a[W-1:0]; b_in = b[W-1:0];
    {clr_a, flip_a, clr_b, flip_b, use_add, flip_out} = c;
    @(negedge clk);
  endtask

  task automatic full_check(int a, int b, logic [5:0] c, string req);
    int e;
    apply(a, b, c);
    e = model(a, b, c);
    check(req, int'(res), e);
    check("R5", int'(is_zero), (e == 0) ? 1 : 0);
    check("R6", int'(is_neg), (e >= 32768) ? 1 : 0);
  endtask

  initial begin
    a_in = '0; b_in = '0;
    {clr_a, flip_a, clr_b, flip_b, use_add, flip_out} = 6'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: all-zero inputs give a zero AND.
    check("R8 idle res", int'(res), 0);
    check("R5 idle flag", int'(is_zero), 1);

    // R7 named control settings
    begin
      int av [4] = '{16'h1234, 16'h0000, 16'hFFFF, 16'h8000};
      int bv [4] = '{16'h00F0, 16'h7FFF, 16'h0001, 16'h8000};
      for (int i = 0; i < 4; i++) begin
        int a = av[i];
        int b = bv[i];
        apply(a, b, 6'b101010); check("R7 zero", int'(res), 0);
        apply(a, b, 6'b111111); check("R7 one", int'(res), 1);
        apply(a, b, 6'b001100); check("R7 pass a", int'(res), a);
        apply(a, b, 6'b000010); check("R7 a+b", int'(res), (a + b) % MODV);
        apply(a, b, 6'b010011); check("R7 a-b", int'(res), (a - b + MODV) % MODV);
        apply(a, b, 6'b000000); check("R7 a&b", int'(res), a & b);
        apply(a, b, 6'b010101); check("R7 a|b", int'(res), a | b);
        apply(a, b, 6'b001111); check("R7 -a", int'(res), (MODV - a) % MODV);
      end
    end

    // R3 carry out of the top bit is dropped
    apply(16'hFFFF, 16'h0001, 6'b000010);
    check("R3 wrap", int'(res), 0);
    check("R5 wrap flag", int'(is_zero), 1);
    // R1 clear precedes complement: clear+flip A gives all ones, AND with B passes B
    apply(16'h1234, 16'hA5A5, 6'b110000);
    check("R1 R2 order", int'(res), 16'hA5A5);
    // R4 output complement of AND
    apply(16'hF0F0, 16'hFF00, 6'b000001);
    check("R4 flip", int'(res), 16'h0FFF);
    // R6 sign boundary
    apply(16'h7FFF, 16'h0001, 6'b000010);
    check("R6 neg", int'(is_neg), 1);
    check("R5 nz", int'(is_zero), 0);
    // R8 change inputs without touching controls; result follows in same cycle
    apply(16'h0003, 16'h0004, 6'b000010);
    check("R8 follow", int'(res), 7);

    // Sweep every control setting with edge and random words (R1 R2 R3 R4)
    for (int c = 0; c < 64; c++) begin
      full_check(16'h0000, 16'hFFFF, c[5:0], "R1 R2 R3 R4 sweep");
      full_check(16'h8000, 16'h7FFF, c[5:0], "R1 R2 R3 R4 sweep");
      for (int k = 0; k < 6; k++)
        full_check(int'($urandom % MODV), int'($urandom % MODV), c[5:0], "R1 R2 R3 R4 rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule